// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block merges the interrupt sources of a serial port into a single interrupt line and an 8-bit identification byte that software reads to learn why it was interrupted. Four sources are tracked: line errors, received data (including the FIFO receive timeout), transmit holding register empty, and modem status change. Each source is held in a sticky pending flag until its own clear action happens. The flag is gated by its enable bit and fed to a fixed priority encoder.

The level sources (line error OR, data ready, timeout, modem delta OR) set their flags while they are high. The transmit-empty flag is set only on a rising edge of the empty condition. It is cleared by a write to the holding register, or by a read of the identification byte while transmit-empty is the source being reported, so a transmit-empty event waiting behind a higher-priority source is kept. The identification byte and the interrupt line are both registered.

Top module: `uart_irq_ident`

## Requirements
- R1: Enable bit positions: `irq_en[0]` gates received data and timeout, `irq_en[1]` gates transmit empty, `irq_en[2]` gates line status, `irq_en[3]` gates modem change. A source whose enable is 0 is never reported, and with all enables 0 the byte shows no interrupt.
- R2: `ident[0]` is active low: 0 means an interrupt is pending, 1 means none. With none pending, `ident[3:1]` is 000.
- R3: `ident[2:1]` carries the code of the highest-priority enabled pending source: 11 line status (highest), 10 received data, 01 transmit empty, 00 modem change (lowest).
- R4: The line, data, timeout and modem flags stay pending after their input falls. Each is cleared by its own strobe: `rd_lstat` for line, `rd_rxbuf` for data and timeout, `rd_mstat` for modem. The next source is then exposed.
- R5: The transmit-empty flag is set on a 0-to-1 edge of `thr_empty` (the edge detector resets to 0). It is cleared by `wr_hold`, or by `rd_ident` only while `ident` reports code 01 with bit 0 low. A level that stays high does not set it again.
- R6: `ident[3]` is 1 when a receive timeout is pending, FIFOs are enabled and the data code 10 is being reported. Otherwise it is 0.
- R7: `ident[7:6]` read 11 when `fifo_on` was 1 in the previous cycle, otherwise 00. `ident[5:4]` are always 0.
- R8: `irq` is a register that always equals the inverse of `ident[0]`.
- R9: After reset `ident` is 8'h01 and `irq` is 0. Input changes sampled at one clock edge appear on `ident` and `irq` at the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 4 | Interrupt enable bits (R1 mapping) |
| rx_ready | input | 1 | Received data available level |
| rx_timeout | input | 1 | Receive FIFO timeout level |
| thr_empty | input | 1 | Transmit holding register empty level |
| line_err | input | 1 | OR of overrun, parity, framing and break flags |
| modem_delta | input | 1 | OR of the modem delta flags |
| fifo_on | input | 1 | FIFOs enabled |
| rd_ident | input | 1 | Identification byte read strobe |
| rd_lstat | input | 1 | Line status register read strobe |
| rd_rxbuf | input | 1 | Receive buffer read strobe |
| rd_mstat | input | 1 | Modem status register read strobe |
| wr_hold | input | 1 | Holding register write strobe |
| irq | output | 1 | Interrupt request, active high |
| ident | output | 8 | Identification byte |

## Verification
Every result is due at the second rising edge after the stimulus edge: the first edge loads the pending flags and the second loads `ident` and `irq`. A clear strobe therefore exposes the next source two edges after it is sampled. The bench drives inputs on falling edges and samples on the falling edge that follows the second rising edge. It holds the source levels through that window so that the flags cannot change between setting and sampling. The table vectors are separated by a clean-up cycle, and the directed sequences wait for the same two-edge window after each strobe before they compare.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  localparam int N_SRC  = 4;
  localparam int CODE_W = 2;
  localparam int ID_W   = 8;

  typedef enum logic [CODE_W-1:0] {
    SRC_MODEM  = 2'b00,
    SRC_THRE   = 2'b01,
    SRC_RXDATA = 2'b10,
    SRC_LINE   = 2'b11
  } irq_src_e;

  // Reorder enable bits (register positions) into code-indexed positions.
  function automatic logic [N_SRC-1:0] en_by_code(logic [N_SRC-1:0] en);
    logic [N_SRC-1:0] r;
    r[SRC_RXDATA] = en[0];
    r[SRC_THRE]   = en[1];
    r[SRC_LINE]   = en[2];
    r[SRC_MODEM]  = en[3];
    return r;
  endfunction

  // Highest set index wins; index equals the reported code.
  function automatic irq_src_e pick_top(logic [N_SRC-1:0] act);
    irq_src_e c;
    c = SRC_MODEM;
    for (int i = 0; i < N_SRC; i++) begin
      if (act[i]) c = irq_src_e'(i);
    end
    return c;
  endfunction

  function automatic logic [ID_W-1:0] build_ident(logic any, irq_src_e code,
                                                  logic tmo, logic fifo);
    return {fifo, fifo, 2'b00, tmo, (any ? code : SRC_MODEM), ~any};
  endfunction

endpackage

// File: rtl/irq_flag.sv
module irq_flag #(
  parameter bit EDGE_SET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sense,
  input  logic clr,
  output logic pend
);
  logic set_ev;

  generate
    if (EDGE_SET) begin : g_edge
      logic sense_d;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sense_d <= 1'b0;
        else        sense_d <= sense;
      end
      assign set_ev = sense & ~sense_d;
    end else begin : g_level
      assign set_ev = sense;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend | set_ev) & ~clr;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [N_SRC-1:0] act,
  input  logic             tmo_pend,
  input  logic             fifo_on,
  output logic [ID_W-1:0]  ident_nx
);
  logic     any;
  irq_src_e top;
  logic     tmo_bit;

  always_comb begin
    any      = |act;
    top      = pick_top(act);
    tmo_bit  = any & fifo_on & tmo_pend & (top == SRC_RXDATA);
    ident_nx = build_ident(any, top, tmo_bit, fifo_on);
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  irq_en,
  input  logic        rx_ready,
  input  logic        rx_timeout,
  input  logic        thr_empty,
  input  logic        line_err,
  input  logic        modem_delta,
  input  logic        fifo_on,
  input  logic        rd_ident,
  input  logic        rd_lstat,
  input  logic        rd_rxbuf,
  input  logic        rd_mstat,
  input  logic        wr_hold,
  output logic        irq,
  output logic [7:0]  ident
);
  logic [N_SRC-1:0] src_sense;
  logic [N_SRC-1:0] src_clr;
  logic [N_SRC-1:0] src_pend;
  logic [N_SRC-1:0] src_act;
  logic             tmo_pend;
  logic             thre_ack;
  logic [ID_W-1:0]  ident_nx;
  logic [ID_W-1:0]  ident_q;
  logic             irq_q;

  // Identification read acknowledges transmit-empty only when it is reported.
  assign thre_ack = rd_ident & ~ident_q[0] &
                    (ident_q[2:1] == SRC_THRE);

  always_comb begin
    src_sense[SRC_LINE]   = line_err;
    src_sense[SRC_RXDATA] = rx_ready;
    src_sense[SRC_THRE]   = thr_empty;
    src_sense[SRC_MODEM]  = modem_delta;
    src_clr[SRC_LINE]     = rd_lstat;
    src_clr[SRC_RXDATA]   = rd_rxbuf;
    src_clr[SRC_THRE]     = wr_hold | thre_ack;
    src_clr[SRC_MODEM]    = rd_mstat;
  end

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      irq_flag #(.EDGE_SET(i == int'(SRC_THRE))) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .sense (src_sense[i]),
        .clr   (src_clr[i]),
        .pend  (src_pend[i])
      );
    end
  endgenerate

  irq_flag #(.EDGE_SET(1'b0)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .sense (rx_timeout),
    .clr   (rd_rxbuf),
    .pend  (tmo_pend)
  );

  // Timeout shares the received-data level and enable.
  logic [N_SRC-1:0] pend_all;
  always_comb begin
    pend_all             = src_pend;
    pend_all[SRC_RXDATA] = src_pend[SRC_RXDATA] | tmo_pend;
    src_act              = pend_all & en_by_code(irq_en);
  end

  irq_prio_enc u_enc (
    .act      (src_act),
    .tmo_pend (tmo_pend),
    .fifo_on  (fifo_on),
    .ident_nx (ident_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ident_q <= 8'h01;
      irq_q   <= 1'b0;
    end else begin
      ident_q <= ident_nx;
      irq_q   <= ~ident_nx[0];
    end
  end

  assign ident = ident_q;
  assign irq   = irq_q;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] irq_en,
  input logic       fifo_on,
  input logic       wr_hold,
  input logic       irq,
  input logic [7:0] ident,
  input logic [3:0] src_pend
);
  AST_IRQ_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == !ident[0]); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ident[5:4] == 2'b00); // R7

  AST_FIFO_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_on |=> ident[7:6] == 2'b11); // R7

  AST_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 4'h0) |=> ident[0]); // R1

  AST_LINE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pend[3] && irq_en[2]) |=> ident[3:0] == 4'b0110); // R3

  AST_TMO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ident[3] |-> (ident[2:1] == 2'b10 && !ident[0])); // R6

  AST_THRE_WR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hold |=> !src_pend[1]); // R5

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ident[0] |-> ident[3:1] == 3'b000); // R2
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_en   (irq_en),
  .fifo_on  (fifo_on),
  .wr_hold  (wr_hold),
  .irq      (irq),
  .ident    (ident),
  .src_pend (src_pend)
);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] irq_en = 4'h0;
  logic       rx_ready = 0, rx_timeout = 0, thr_empty = 0, line_err = 0;
  logic       modem_delta = 0, fifo_on = 0;
  logic       rd_ident = 0, rd_lstat = 0, rd_rxbuf = 0, rd_mstat = 0, wr_hold = 0;
  logic       irq;
  logic [7:0] ident;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  uart_irq_ident u_dut (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .thr_empty(thr_empty), .line_err(line_err),
    .modem_delta(modem_delta), .fifo_on(fifo_on), .rd_ident(rd_ident),
    .rd_lstat(rd_lstat), .rd_rxbuf(rd_rxbuf), .rd_mstat(rd_mstat),
    .wr_hold(wr_hold), .irq(irq), .ident(ident)
  );

  // {enable[3:0], rx,tmo,thre,line,modem,fifo, expected ident[7:0]}
  localparam int NV = 12;
  localparam logic [17:0] VEC [NV] = '{
    {4'hF, 6'b000000, 8'h01},  // R2 none pending
    {4'hF, 6'b000010, 8'h00},  // R3 modem only
    {4'hF, 6'b001010, 8'h02},  // R3 thre over modem
    {4'hF, 6'b101010, 8'h04},  // R3 data over thre
    {4'hF, 6'b100100, 8'h06},  // R3 line over data
    {4'hF, 6'b010001, 8'hCC},  // R6 timeout, fifo on
    {4'hF, 6'b100001, 8'hC4},  // R7 fifo bits
    {4'hB, 6'b000110, 8'h00},  // R1 line masked
    {4'h0, 6'b111111, 8'hC1},  // R1 nothing enabled
    {4'h1, 6'b010000, 8'h04},  // R6 timeout, fifo off
    {4'h2, 6'b001000, 8'h02},  // R1 thre enable bit 1
    {4'h8, 6'b101100, 8'h01}   // R1 only modem enabled
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic sources_low();
    rx_ready = 0; rx_timeout = 0; thr_empty = 0; line_err = 0; modem_delta = 0;
  endtask

  task automatic cleanup();
    sources_low();
    rd_lstat = 1; rd_rxbuf = 1; rd_mstat = 1; wr_hold = 1;
    tick(1);
    rd_lstat = 0; rd_rxbuf = 0; rd_mstat = 0; wr_hold = 0;
    tick(1);
  endtask

  task automatic pulse(ref logic s);
    s = 1; tick(1); s = 0; tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R9 reset ident", ident, 8'h01);
    chk("R9 reset irq", {7'b0, irq}, 8'h00);
    rst_n = 1;
    tick(1);

    // Table walk: R1 R2 R3 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      cleanup();
      irq_en      = VEC[i][17:14];
      rx_ready    = VEC[i][13];
      rx_timeout  = VEC[i][12];
      thr_empty   = VEC[i][11];
      line_err    = VEC[i][10];
      modem_delta = VEC[i][9];
      fifo_on     = VEC[i][8];
      tick(2);
      chk($sformatf("R3 vector %0d ident", i), ident, VEC[i][7:0]);
      chk($sformatf("R8 vector %0d irq", i), {7'b0, irq}, {7'b0, ~VEC[i][0]});
    end

    // R4: priority exposure as each source is cleared
    cleanup();
    irq_en = 4'hF; fifo_on = 0;
    line_err = 1; rx_ready = 1; modem_delta = 1;
    tick(1);
    sources_low();
    tick(2);
    chk("R4 sticky line after input drop", ident, 8'h06);
    pulse(rd_lstat);
    chk("R4 data exposed after line read", ident, 8'h04);
    pulse(rd_rxbuf);
    chk("R4 modem exposed after rxbuf read", ident, 8'h00);
    pulse(rd_mstat);
    chk("R4 none after modem read", ident, 8'h01);

    // R5: ident read clears thre when reported; level held does not re-set
    cleanup();
    irq_en = 4'hF;
    thr_empty = 1;
    tick(2);
    chk("R5 thre reported", ident, 8'h02);
    pulse(rd_ident);
    chk("R5 thre cleared by ident read", ident, 8'h01);
    tick(2);
    chk("R5 held level no re-set", ident, 8'h01);

    // R5: thre not lost behind data; ident read while data reported
    cleanup();
    irq_en = 4'hF;
    thr_empty = 1; rx_ready = 1;
    tick(2);
    rx_ready = 0;
    chk("R5 data hides thre", ident, 8'h04);
    pulse(rd_ident);
    chk("R5 data still after ident read", ident, 8'h04);
    pulse(rd_rxbuf);
    chk("R5 thre kept behind data", ident, 8'h02);
    pulse(wr_hold);
    chk("R5 thre cleared by hold write", ident, 8'h01);

    // R6: timeout bit clears with receive buffer read
    cleanup();
    irq_en = 4'h1; fifo_on = 1;
    rx_timeout = 1;
    tick(1);
    rx_timeout = 0;
    tick(1);
    chk("R6 timeout flagged", ident, 8'hCC);
    pulse(rd_rxbuf);
    chk("R6 timeout cleared", ident, 8'hC1);
    chk("R8 irq low when idle", {7'b0, irq}, 8'h00);

    // R9: two-edge latency
    cleanup();
    irq_en = 4'h8; fifo_on = 0;
    modem_delta = 1;
    tick(1);
    chk("R9 not yet after one edge", ident, 8'h01);
    tick(1);
    chk("R9 visible after two edges", ident, 8'h00);
    modem_delta = 0;
    tick(1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule